// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block fronts a simulated one-time-programmable fuse array of 4096 bits, held as 128 words of 32 bits. Software reaches it through a simple request port: a program request ORs its data into one word after a fixed busy period, and a read request returns one word on the next cycle. Because a program can only OR, no bit that is 1 can ever go back to 0.

The array is split into four regions: device parameters (words 0-15), a free user region of 1792 bits (words 16-71), six key blocks of 256 bits each (words 72-119, block k at words 72+8k to 79+8k), and control words (120-127). Control word 120 carries the debug-disable bits, one read-protect bit per key block and one write-lock bit per region. Word 121 holds a 4-bit purpose code per key block. A read-protected key block reads as zero from the software port but is still delivered on a separate combinational hardware key port, and only to the consumer whose ID equals the block's purpose code.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset every word reads 0, and host_busy, host_err, host_rvalid, jtag_dis and usb_dis are all 0.
- R2: An accepted program sets the target word to its old value ORed with host_wdata; no sequence of programs ever clears a bit that is already 1, including a program with all-zero data.
- R3: An accepted program holds host_busy high for exactly PROG_CYCLES cycles and the word takes its new value in the cycle host_busy falls; any request (program or read) made while host_busy is high is ignored.
- R4: A read request while idle gives host_rvalid high on the next cycle with host_rdata equal to the stored word; user-region words (16-71) always read back as stored.
- R5: When bit 8+k of word 120 is set, a software read of any word of key block k returns all zeros; other blocks and regions are unaffected.
- R6: When bit 16+r of word 120 is set (r=0 device, 1 user, 2 key, 3 control), a program to region r leaves the array unchanged, does not raise host_busy, and sets host_err; host_err stays set until the next accepted program, which clears it.
- R7: On the key port, with key_req high, key_data is word 72+8*key_blk+key_wsel and key_denied is 0 only when key_blk < 6, the purpose code in word 121 bits [4*key_blk+3:4*key_blk] is nonzero and equals key_cid; otherwise key_data is 0 and key_denied is 1. Read protection does not affect this port.
- R8: jtag_dis follows bit 0 and usb_dis follows bit 1 of word 120; once high they stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request strobe |
| host_we | input | 1 | 1 = program, 0 = read |
| host_addr | input | 7 | Word address |
| host_wdata | input | 32 | Bits to set |
| host_busy | output | 1 | Program in progress |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| host_err | output | 1 | Sticky locked-region error |
| key_req | input | 1 | Hardware key request |
| key_cid | input | 4 | Consumer ID |
| key_blk | input | 3 | Key block index |
| key_wsel | input | 3 | Word within key block |
| key_data | output | 32 | Key word or zeros |
| key_denied | output | 1 | Request refused |
| jtag_dis | output | 1 | JTAG debug disable |
| usb_dis | output | 1 | USB debug disable |

## Verification
The assertions watch on every cycle that no stored bit ever falls, that an accepted program raises busy while a locked one raises the error without busy, that a denied key request carries zero data, and that the debug-disable outputs never drop. Only the bench scenarios can show the stored values themselves: the OR result after random programs, the exact busy length, requests dropped while busy, zeroed reads of protected blocks, and the purpose-code match on the key port.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
    localparam int WORDS       = 128;
    localparam int DW          = 32;
    localparam int AW          = $clog2(WORDS);
    localparam int KEY_BLOCKS  = 6;
    localparam int KEY_WORDS   = 8;
    localparam int KW_BITS     = $clog2(KEY_WORDS);
    localparam int KB_W        = $clog2(KEY_BLOCKS);
    localparam int PURP_W      = 4;
    localparam int NREG        = 4;
    localparam int USER_BASE   = 16;
    localparam int KEY_BASE    = 72;
    localparam int CTRL_BASE   = KEY_BASE + KEY_BLOCKS * KEY_WORDS;
    localparam int CTRL_WORD   = CTRL_BASE;
    localparam int PURP_WORD   = CTRL_BASE + 1;
    localparam int JTAG_BIT    = 0;
    localparam int USB_BIT     = 1;
    localparam int RPROT_LSB   = 8;
    localparam int WLOCK_LSB   = 16;

    typedef enum logic [1:0] {
        REG_DEV  = 2'd0,
        REG_USER = 2'd1,
        REG_KEY  = 2'd2,
        REG_CTRL = 2'd3
    } region_e;

    function automatic region_e region_of(logic [AW-1:0] a);
        if (int'(a) < USER_BASE)      return REG_DEV;
        else if (int'(a) < KEY_BASE)  return REG_USER;
        else if (int'(a) < CTRL_BASE) return REG_KEY;
        else                          return REG_CTRL;
    endfunction

    function automatic logic [KB_W-1:0] block_of(logic [AW-1:0] a);
        logic [AW-1:0] off;
        off = a - AW'(KEY_BASE);
        return KB_W'(off >> KW_BITS);
    endfunction
endpackage

// File: rtl/fuse_store.sv
module fuse_store
    import fuse_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_en,
    input  logic [AW-1:0]             commit_addr,
    input  logic [DW-1:0]             commit_data,
    output logic [WORDS-1:0][DW-1:0]  words_o
);
    logic [WORDS-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (commit_en)
            mem_d[commit_addr] = mem_q[commit_addr] | commit_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign words_o = mem_q;

    for (genvar i = 0; i < WORDS; i++) begin : g_mono
        // R2
        no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(mem_q[i]) & ~mem_q[i]) == '0));
    end
endmodule

// File: rtl/fuse_host.sv
module fuse_host
    import fuse_pkg::*;
#(
    parameter int PROG_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic                  we_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [DW-1:0]         wdata_i,
    input  logic [DW-1:0]         rd_word_i,
    input  logic [NREG-1:0]       lock_i,
    input  logic [KEY_BLOCKS-1:0] prot_i,
    output logic                  busy_o,
    output logic                  rvalid_o,
    output logic [DW-1:0]         rdata_o,
    output logic                  err_o,
    output logic                  commit_en_o,
    output logic [AW-1:0]         commit_addr_o,
    output logic [DW-1:0]         commit_data_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          err;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } host_st_t;

    host_st_t s_d, s_q;
    region_e  reg_sel;
    logic     locked;
    logic     hidden;

    always_comb begin
        reg_sel = region_of(addr_i);
        locked  = lock_i[reg_sel];
        hidden  = (reg_sel == REG_KEY) && prot_i[block_of(addr_i)];
    end

    always_comb begin
        s_d         = s_q;
        s_d.rvalid  = 1'b0;
        commit_en_o = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                commit_en_o = 1'b1;
                s_d.busy    = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (req_i) begin
            if (we_i) begin
                if (locked) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.cnt  = CW'(PROG_CYCLES - 1);
                    s_d.addr = addr_i;
                    s_d.data = wdata_i;
                    s_d.err  = 1'b0;
                end
            end else begin
                s_d.rvalid = 1'b1;
                s_d.rdata  = hidden ? '0 : rd_word_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o        = s_q.busy;
    assign rvalid_o      = s_q.rvalid;
    assign rdata_o       = s_q.rdata;
    assign err_o         = s_q.err;
    assign commit_addr_o = s_q.addr;
    assign commit_data_o = s_q.data;

    // R3
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i && we_i && !lock_i[region_of(addr_i)]) |=> busy_o);

    // R6
    lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i && we_i && lock_i[region_of(addr_i)]) |=> (err_o && !busy_o));

    // R3
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !rvalid_o);
endmodule

// File: rtl/fuse_keyport.sv
module fuse_keyport
    import fuse_pkg::*;
#(
    parameter int CID_W = PURP_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORDS-1:0][DW-1:0]  words_i,
    input  logic                      req_i,
    input  logic [CID_W-1:0]          cid_i,
    input  logic [2:0]                blk_i,
    input  logic [KW_BITS-1:0]        wsel_i,
    output logic [DW-1:0]             data_o,
    output logic                      denied_o
);
    logic              in_range;
    logic [2:0]        bsel;
    logic [PURP_W-1:0] purpose;
    logic              grant;
    logic [AW-1:0]     widx;

    always_comb begin
        in_range = (int'(blk_i) < KEY_BLOCKS);
        bsel     = in_range ? blk_i : 3'd0;
        purpose  = words_i[PURP_WORD][bsel*PURP_W +: PURP_W];
        grant    = req_i && in_range && (purpose != '0) && (CID_W'(purpose) == cid_i);
        widx     = AW'(KEY_BASE) + AW'({bsel, wsel_i});
        data_o   = grant ? words_i[widx] : '0;
        denied_o = req_i && !grant;
    end

    // R7
    deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        denied_o |-> (data_o == '0));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> (!denied_o && data_o == '0));
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
    import fuse_pkg::*;
#(
    parameter int PROG_CYCLES = 8,
    parameter int CID_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [6:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic              host_busy,
    output logic              host_rvalid,
    output logic [31:0]       host_rdata,
    output logic              host_err,
    input  logic              key_req,
    input  logic [CID_W-1:0]  key_cid,
    input  logic [2:0]        key_blk,
    input  logic [2:0]        key_wsel,
    output logic [31:0]       key_data,
    output logic              key_denied,
    output logic              jtag_dis,
    output logic              usb_dis
);
    logic [WORDS-1:0][DW-1:0] words;
    logic                     commit_en;
    logic [AW-1:0]            commit_addr;
    logic [DW-1:0]            commit_data;
    logic [DW-1:0]            ctrl_w;
    logic [NREG-1:0]          lock_v;
    logic [KEY_BLOCKS-1:0]    prot_v;

    assign ctrl_w   = words[CTRL_WORD];
    assign lock_v   = ctrl_w[WLOCK_LSB +: NREG];
    assign prot_v   = ctrl_w[RPROT_LSB +: KEY_BLOCKS];
    assign jtag_dis = ctrl_w[JTAG_BIT];
    assign usb_dis  = ctrl_w[USB_BIT];

    fuse_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .words_o     (words)
    );

    fuse_host #(.PROG_CYCLES(PROG_CYCLES)) u_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (host_req),
        .we_i          (host_we),
        .addr_i        (host_addr),
        .wdata_i       (host_wdata),
        .rd_word_i     (words[host_addr]),
        .lock_i        (lock_v),
        .prot_i        (prot_v),
        .busy_o        (host_busy),
        .rvalid_o      (host_rvalid),
        .rdata_o       (host_rdata),
        .err_o         (host_err),
        .commit_en_o   (commit_en),
        .commit_addr_o (commit_addr),
        .commit_data_o (commit_data)
    );

    fuse_keyport #(.CID_W(CID_W)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .words_i  (words),
        .req_i    (key_req),
        .cid_i    (key_cid),
        .blk_i    (key_blk),
        .wsel_i   (key_wsel),
        .data_o   (key_data),
        .denied_o (key_denied)
    );

    // R8
    jtag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jtag_dis |=> jtag_dis);

    // R8
    usb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usb_dis |=> usb_dis);
endmodule

// File: tb/sim_fuse_ctrl.sv
module sim_fuse_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_CYC   = 8;

    logic        clk = 0, rst_n = 0;
    logic        host_req = 0, host_we = 0;
    logic [6:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic        host_busy, host_rvalid, host_err;
    logic [31:0] host_rdata;
    logic        key_req = 0;
    logic [3:0]  key_cid = 0;
    logic [2:0]  key_blk = 0, key_wsel = 0;
    logic [31:0] key_data;
    logic        key_denied, jtag_dis, usb_dis;

    int total = 0, bad = 0;
    logic [31:0] model [128];
    logic        exp_err = 0;

    fuse_ctrl #(.PROG_CYCLES(PROG_CYC), .CID_W(4)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int region(input int a);
        if (a < 16) return 0;
        if (a < 72) return 1;
        if (a < 120) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        if (region(a) == 2 && model[120][8 + (a - 72) / 8]) return 32'h0;
        return model[a];
    endfunction

    task automatic do_prog(input int a, input logic [31:0] d, output int bcyc);
        logic lk;
        lk = model[120][16 + region(a)];
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = 7'(a); host_wdata = d;
        @(negedge clk);
        host_req = 0; host_we = 0;
        bcyc = 0;
        while (host_busy) begin bcyc++; @(negedge clk); end
        if (lk) exp_err = 1;
        else begin model[a] = model[a] | d; exp_err = 0; end
        chk("R6 err flag", 32'(host_err), 32'(exp_err));
    endtask

    task automatic do_read(input int a, output logic [31:0] v, output logic vld);
        @(negedge clk);
        host_req = 1; host_we = 0; host_addr = 7'(a);
        @(negedge clk);
        host_req = 0;
        v = host_rdata; vld = host_rvalid;
    endtask

    task automatic key_get(input int cid, input int blk, input int ws,
                           output logic [31:0] d, output logic dn);
        @(negedge clk);
        key_req = 1; key_cid = 4'(cid); key_blk = 3'(blk); key_wsel = 3'(ws);
        #1; d = key_data; dn = key_denied;
        key_req = 0;
    endtask

    initial begin
        int bc;
        logic [31:0] v;
        logic vld, dn;
        void'($urandom(32'd4242));
        for (int i = 0; i < 128; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", 32'(host_busy), 0);
        chk("R1 err", 32'(host_err), 0);
        chk("R1 rvalid", 32'(host_rvalid), 0);
        chk("R1 jtag", 32'(jtag_dis), 0);
        chk("R1 usb", 32'(usb_dis), 0);
        do_read(40, v, vld);
        chk("R1 word zero", v, 0);

        // R3 busy length
        do_prog(20, 32'h0000_00f0, bc);
        chk("R3 busy cycles", 32'(bc), PROG_CYC);
        do_read(20, v, vld);
        chk("R4 rvalid", 32'(vld), 1);
        chk("R4 user readback", v, 32'h0000_00f0);

        // R2 random programs over words 0..119, then full readback
        for (int n = 0; n < 60; n++) begin
            int a;
            logic [31:0] d;
            a = $urandom_range(0, 119);
            d = $urandom & $urandom;
            do_prog(a, d, bc);
        end
        for (int a = 0; a < 120; a++) begin
            do_read(a, v, vld);
            chk("R2 OR accumulate", v, exp_read(a));
        end

        // R2 zero-data and complement programs never clear bits
        v = model[30];
        do_prog(30, 32'h0, bc);
        do_read(30, v, vld);
        chk("R2 zero data keeps bits", v, model[30]);
        do_prog(31, ~model[31], bc);
        do_read(31, v, vld);
        chk("R2 all ones after complement", v, 32'hffff_ffff);

        // R3 requests while busy are ignored
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = 7'd50; host_wdata = 32'h1;
        @(negedge clk);
        host_addr = 7'd51; host_wdata = 32'hffff_ffff;
        @(negedge clk);
        host_we = 0; host_addr = 7'd20;
        @(negedge clk);
        chk("R3 read while busy ignored", 32'(host_rvalid), 0);
        host_req = 0;
        while (host_busy) @(negedge clk);
        model[50] = model[50] | 32'h1;
        do_read(51, v, vld);
        chk("R3 program while busy ignored", v, model[51]);
        do_read(50, v, vld);
        chk("R3 first program landed", v, model[50]);

        // R7 key port: block 1 purpose 5
        do_prog(83, 32'hcafe_0001, bc);
        do_prog(121, 32'h0000_0050, bc);
        key_get(5, 1, 3, v, dn);
        chk("R7 granted data", v, model[83]);
        chk("R7 granted flag", 32'(dn), 0);
        key_get(4, 1, 3, v, dn);
        chk("R7 wrong cid data", v, 0);
        chk("R7 wrong cid denied", 32'(dn), 1);
        key_get(0, 0, 0, v, dn);
        chk("R7 zero purpose denied", 32'(dn), 1);
        key_get(5, 7, 0, v, dn);
        chk("R7 block out of range denied", 32'(dn), 1);
        chk("R7 block out of range data", v, 0);

        // R5 read protect block 1
        do_prog(120, 32'h0000_0200, bc);
        do_read(83, v, vld);
        chk("R5 protected reads zero", v, 0);
        do_read(75, v, vld);
        chk("R5 other block visible", v, model[75]);
        key_get(5, 1, 3, v, dn);
        chk("R7 protected still on key port", v, model[83]);

        // R8 debug disables
        chk("R8 jtag before", 32'(jtag_dis), 0);
        do_prog(120, 32'h0000_0001, bc);
        chk("R8 jtag set", 32'(jtag_dis), 1);
        chk("R8 usb still clear", 32'(usb_dis), 0);
        do_prog(120, 32'h0000_0002, bc);
        chk("R8 usb set", 32'(usb_dis), 1);

        // R6 lock user region
        do_prog(120, 32'h0002_0000, bc);
        v = model[25];
        do_prog(25, 32'hffff_ffff, bc);
        chk("R6 locked no busy", 32'(bc), 0);
        chk("R6 err set", 32'(host_err), 1);
        do_read(25, v, vld);
        chk("R6 locked word unchanged", v, model[25]);
        chk("R6 err sticky after read", 32'(host_err), 1);
        do_prog(3, 32'h0000_8000, bc);
        chk("R6 err cleared", 32'(host_err), 0);
        do_read(3, v, vld);
        chk("R4 device word readback", v, model[3]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule